// File: doc/BRIEF.md
# Six-Step Commutation Phase Decoder

This block turns a signed electrical rotor angle in degrees, a duty magnitude in percent and a rotation direction into one drive code per phase of a three-phase inverter. In every sector one phase has its high side modulated at the requested duty, one phase has its low side held fully on, and one phase is left floating. The code values are chosen so that a downstream carrier comparator can decode them directly. A float is all zeros, a low-side-on phase is all ones, and a modulated phase carries the duty value.

The angle may lie anywhere in the signed input range. It is first folded into 0..359 and then decoded into one of six 60° sectors, which are offset by 30°. The direction bit chooses between two distinct commutation patterns and usually comes from the sign of the speed loop's torque command. The outputs are registered and change only on a sample-enable pulse, so the inverter stage sees one coherent update per control step.

Top module: `six_step_decoder`

## Requirements
- R1: The signed `angle` is reduced modulo 360, and 360 is added when the remainder is negative. Any two angles that differ by a multiple of 360 therefore produce the same outputs, across the whole signed input range.
- R2: Sector 0 covers normalised angles 330..359 and 0..29. Sectors 1 to 5 start at 30, 90, 150, 210 and 270 and are each 60° wide. Every lower bound belongs to the sector that it opens.
- R3: With `dir_rev` = 0, sectors 0 to 5 give the phase roles A/B/C as follows: float/PWM/low, low/PWM/float, low/float/PWM, float/low/PWM, PWM/low/float, PWM/float/low.
- R4: With `dir_rev` = 1, sectors 0 to 5 give the phase roles A/B/C as follows: float/low/PWM, PWM/low/float, PWM/float/low, float/PWM/low, low/PWM/float, low/float/PWM.
- R5: A floating phase outputs code 8'h00, a low-side-on phase outputs 8'hFF, and a PWM phase outputs the limited duty value.
- R6: The duty value is limited to 99, so inputs from 100 to 127 give 99. A PWM code therefore never exceeds 99 and never equals 8'hFF.
- R7: The outputs take new values only at a clock edge where `sample_en` is 1. At every other edge they keep their values, whatever the other inputs do.
- R8: While `rst_n` is low, and after reset until the first sample, all three phases output 8'h00 (float).
- R9: After any sample, exactly one of the three phases outputs 8'hFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sample_en | input | 1 | Captures a new set of phase codes when 1 |
| angle | input | 16 | Signed electrical angle in degrees |
| duty | input | 7 | Unsigned duty in percent |
| dir_rev | input | 1 | 0 = forward pattern, 1 = reverse pattern |
| ph_a | output | 8 | Drive code, phase A |
| ph_b | output | 8 | Drive code, phase B |
| ph_c | output | 8 | Drive code, phase C |

## Verification
The bench builds the block with its default parameters: a 16-bit signed angle, a 7-bit duty, 8-bit codes and a duty limit of 99. With a 16-bit angle the folding can be tested at the range extremes -32768 and 32767 as well as across a dense sweep from -720 to +720 in both directions. With a 7-bit duty the inputs from 100 to 127 that the limit must catch can all be driven. A behavioural reference computes the expected codes from sector tables. It is compared with the outputs on every clock, including the cycles where `sample_en` is 0 and the inputs change freely.

// File: rtl/six_step_decoder.sv
module six_step_decoder #(
  parameter int ANGLE_W  = 16,
  parameter int DUTY_W   = 7,
  parameter int CODE_W   = 8,
  parameter int DUTY_MAX = 99
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      sample_en,
  input  logic signed [ANGLE_W-1:0] angle,
  input  logic [DUTY_W-1:0]         duty,
  input  logic                      dir_rev,
  output logic [CODE_W-1:0]         ph_a,
  output logic [CODE_W-1:0]         ph_b,
  output logic [CODE_W-1:0]         ph_c
);

  localparam logic signed [ANGLE_W-1:0] TURN = ANGLE_W'(360);
  localparam logic signed [ANGLE_W-1:0] E30  = ANGLE_W'(30);
  localparam logic signed [ANGLE_W-1:0] E90  = ANGLE_W'(90);
  localparam logic signed [ANGLE_W-1:0] E150 = ANGLE_W'(150);
  localparam logic signed [ANGLE_W-1:0] E210 = ANGLE_W'(210);
  localparam logic signed [ANGLE_W-1:0] E270 = ANGLE_W'(270);
  localparam logic signed [ANGLE_W-1:0] E330 = ANGLE_W'(330);
  localparam logic [CODE_W-1:0] CODE_LOW = '1;
  localparam logic [CODE_W-1:0] CODE_FLT = '0;
  localparam logic [DUTY_W-1:0] DUTY_LIM = DUTY_W'(DUTY_MAX);

  typedef enum logic [1:0] {ROLE_FLT, ROLE_PWM, ROLE_LOW} role_t;

  logic signed [ANGLE_W-1:0] rem, norm;
  logic [2:0] fsec, sec;
  logic [CODE_W-1:0] duty_code;

  assign rem  = angle % TURN;
  assign norm = rem[ANGLE_W-1] ? rem + TURN : rem;

  always_comb begin
    if      (norm < E30)  fsec = 3'd0;
    else if (norm < E90)  fsec = 3'd1;
    else if (norm < E150) fsec = 3'd2;
    else if (norm < E210) fsec = 3'd3;
    else if (norm < E270) fsec = 3'd4;
    else if (norm < E330) fsec = 3'd5;
    else                  fsec = 3'd0;
  end

  assign sec = !dir_rev ? fsec : (fsec >= 3'd3 ? fsec - 3'd3 : fsec + 3'd3);

  assign duty_code = CODE_W'((duty > DUTY_LIM) ? DUTY_LIM : duty);

  function automatic role_t role_a(input logic [2:0] s);
    case (s)
      3'd1, 3'd2: return ROLE_LOW;
      3'd4, 3'd5: return ROLE_PWM;
      default:    return ROLE_FLT;
    endcase
  endfunction

  function automatic role_t role_b(input logic [2:0] s);
    case (s)
      3'd0, 3'd1: return ROLE_PWM;
      3'd3, 3'd4: return ROLE_LOW;
      default:    return ROLE_FLT;
    endcase
  endfunction

  function automatic role_t role_c(input logic [2:0] s);
    case (s)
      3'd0, 3'd5: return ROLE_LOW;
      3'd2, 3'd3: return ROLE_PWM;
      default:    return ROLE_FLT;
    endcase
  endfunction

  function automatic logic [CODE_W-1:0] encode(input role_t r, input logic [CODE_W-1:0] d);
    case (r)
      ROLE_PWM: return d;
      ROLE_LOW: return CODE_LOW;
      default:  return CODE_FLT;
    endcase
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_a <= CODE_FLT;
      ph_b <= CODE_FLT;
      ph_c <= CODE_FLT;
    end else if (sample_en) begin
      ph_a <= encode(role_a(sec), duty_code);
      ph_b <= encode(role_b(sec), duty_code);
      ph_c <= encode(role_c(sec), duty_code);
    end
  end

endmodule

// File: rtl/six_step_decoder_chk.sv
module six_step_decoder_chk #(
  parameter int DUTY_W   = 7,
  parameter int CODE_W   = 8,
  parameter int DUTY_MAX = 99
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sample_en,
  input logic [DUTY_W-1:0] duty,
  input logic [CODE_W-1:0] ph_a,
  input logic [CODE_W-1:0] ph_b,
  input logic [CODE_W-1:0] ph_c
);

  localparam logic [CODE_W-1:0] ALL1 = '1;
  localparam logic [CODE_W-1:0] LIM  = CODE_W'(DUTY_MAX);

  logic [CODE_W-1:0] duty_lim;
  assign duty_lim = (CODE_W'(duty) > LIM) ? LIM : CODE_W'(duty);

  // R8
  reset_float_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (ph_a == '0 && ph_b == '0 && ph_c == '0));

  // R7
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sample_en |=> ($stable(ph_a) && $stable(ph_b) && $stable(ph_c)));

  // R9
  one_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sample_en |=> ($countones({ph_a == ALL1, ph_b == ALL1, ph_c == ALL1}) == 1));

  // R5
  code_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sample_en |=> ((ph_a == '0 || ph_a == ALL1 || ph_a == $past(duty_lim)) &&
                   (ph_b == '0 || ph_b == ALL1 || ph_b == $past(duty_lim)) &&
                   (ph_c == '0 || ph_c == ALL1 || ph_c == $past(duty_lim))));

  // R6
  duty_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_a <= LIM || ph_a == ALL1) && (ph_b <= LIM || ph_b == ALL1) &&
    (ph_c <= LIM || ph_c == ALL1));

endmodule

bind six_step_decoder six_step_decoder_chk #(
  .DUTY_W(DUTY_W), .CODE_W(CODE_W), .DUTY_MAX(DUTY_MAX)
) u_chk (
  .clk(clk), .rst_n(rst_n), .sample_en(sample_en), .duty(duty),
  .ph_a(ph_a), .ph_b(ph_b), .ph_c(ph_c)
);

// File: tb/test_six_step_decoder.sv
`timescale 1ns/1ps
module test_six_step_decoder;

  logic clk = 0;
  logic rst_n = 0;
  logic sample_en = 0;
  logic signed [15:0] angle = 0;
  logic [6:0] duty = 0;
  logic dir_rev = 0;
  logic [7:0] ph_a, ph_b, ph_c;

  six_step_decoder i_six_step_decoder (
    .clk(clk), .rst_n(rst_n), .sample_en(sample_en), .angle(angle),
    .duty(duty), .dir_rev(dir_rev), .ph_a(ph_a), .ph_b(ph_b), .ph_c(ph_c)
  );

  always #4 clk = ~clk;

  string FWD[6] = '{"FPL", "LPF", "LFP", "FLP", "PLF", "PFL"};
  string REV[6] = '{"FLP", "PLF", "PFL", "FPL", "LPF", "LFP"};

  int checks = 0, errors = 0, cycles = 0;
  int exp_c[3] = '{0, 0, 0};
  bit sampled = 0;
  bit done = 0;
  string cur_req = "R8";

  function automatic int ref_code(int ang, int d, bit rev, int ph);
    int a;
    int s;
    string pat;
    byte c;
    a = ang % 360;
    if (a < 0) a += 360;
    s = ((a + 30) % 360) / 60;
    pat = rev ? REV[s] : FWD[s];
    c = pat[ph];
    if (c == "P") return (d > 99) ? 99 : d;
    if (c == "L") return 255;
    return 0;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      exp_c = '{0, 0, 0};
      sampled = 0;
    end else if (sample_en) begin
      for (int p = 0; p < 3; p++) exp_c[p] = ref_code(angle, duty, dir_rev, p);
      sampled = 1;
    end
  end

  task automatic check(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d (t=%0t)", req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!done) begin
      check(cur_req, "ph_a", ph_a, exp_c[0]);
      check(cur_req, "ph_b", ph_b, exp_c[1]);
      check(cur_req, "ph_c", ph_c, exp_c[2]);
      // R9: one low-side phase once a sample has been taken
      if (sampled && rst_n)
        check("R9", "low count", int'(ph_a == 8'hFF) + int'(ph_b == 8'hFF) + int'(ph_c == 8'hFF), 1);
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles >= 100000 && !done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic apply(int ang, int d, bit rev, bit en, string req);
    @(negedge clk);
    #1;
    angle = 16'(ang);
    duty = 7'(d);
    dir_rev = rev;
    sample_en = en;
    cur_req = req;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1 rst_n = 1;
    // R8: after reset, before any sample
    apply(0, 50, 0, 0, "R8");
    apply(0, 50, 0, 0, "R8");
    // R3: forward sweep
    for (int a = -720; a <= 720; a++) apply(a, 37, 0, 1, "R3");
    // R4: reverse sweep
    for (int a = -720; a <= 720; a++) apply(a, 63, 1, 1, "R4");
    // R2: sector edges
    foreach (FWD[i]) begin
      int e;
      e = (i == 0) ? 330 : 30 + 60 * (i - 1);
      apply(e - 1, 20, 0, 1, "R2");
      apply(e, 20, 0, 1, "R2");
      apply(e - 1, 20, 1, 1, "R2");
      apply(e, 20, 1, 1, "R2");
    end
    // R1: range extremes and multiples of a turn
    apply(-32768, 45, 0, 1, "R1");
    apply(32767, 45, 0, 1, "R1");
    apply(-32768, 45, 1, 1, "R1");
    apply(32767, 45, 1, 1, "R1");
    apply(32400, 45, 0, 1, "R1");
    apply(-32400, 45, 1, 1, "R1");
    apply(-360, 45, 0, 1, "R1");
    apply(-1, 45, 0, 1, "R1");
    // R5 and R6: duty values across the limit
    for (int d = 0; d < 128; d++) apply(200, d, d[0], 1, (d > 99) ? "R6" : "R5");
    // R7: hold while sample_en is low
    apply(100, 40, 0, 1, "R7");
    for (int k = 0; k < 20; k++) apply(k * 53 - 400, 127 - k, k[0], 0, "R7");
    apply(250, 10, 1, 1, "R7");
    // R8: reset in the middle of operation
    @(negedge clk);
    #1 rst_n = 0;
    cur_req = "R8";
    repeat (2) @(negedge clk);
    #1 rst_n = 1;
    apply(15, 80, 0, 0, "R8");
    apply(15, 80, 0, 1, "R8");
    apply(15, 80, 0, 0, "R3");
    @(negedge clk);
    #2 done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule